// File: doc/BRIEF.md
# Mode-Banked General Register File with Status Registers

This block holds the sixteen 32-bit general registers of a processor core that runs in seven operating modes, along with one current status word and one saved status word for each exception mode. Registers r0 to r7 and the program counter r15 exist once. Registers r8 to r12 have a second physical copy that only the fast-interrupt mode uses. Registers r13 and r14 have one copy for each exception mode, plus one copy that User and System share. The mode field of the current status word selects the copy that every access reaches. Changing that field through the status write port therefore switches the visible registers in the same edge, and no data is copied.

The core reads two operands and writes one result each cycle, using a 4-bit register number. It updates a status word through a separate port. That port carries a per-byte field mask and a select that picks the current word or the saved word of the current mode. The block also reports whether the current mode is privileged and whether the mode has a saved status word. It raises a one-cycle flag when a status write tries to install a mode encoding that does not exist.

Top module: `banked_regfile`

## Requirements
- R1: After reset, cpsr_o reads 0x000000D3. This is Supervisor mode 10011 in bits 4:0, F (bit 6) set and I (bit 7) set. Every general register reads 0 (r15 reads 8), spsr_o is 0 and mode_err_o is 0.
- R2: The valid 5-bit mode codes are 10000 User, 10001 FIQ, 10010 IRQ, 10011 Supervisor, 10111 Abort, 11011 Undefined and 11111 System. privileged_o is 1 in every mode except User. has_saved_o is 1 in every mode except User and System.
- R3: r0 to r7 and r15 are single registers that every mode shares. A read of index 15 returns the stored value plus 8, modulo 2^32.
- R4: r8 to r12 have one copy for FIQ and one copy that all other modes share.
- R5: r13 and r14 have separate copies for FIQ, IRQ, Supervisor, Abort and Undefined, plus one copy that User and System share.
- R6: A general write reaches the copy selected by the mode held before the clock edge. This holds even when a status write in the same cycle changes the mode.
- R7: The two read ports are combinational and independent. A write shows on the read ports from the cycle after its edge onward.
- R8: On a status write, mask bit 3 enables bits 31:24, bit 2 enables bits 23:16, bit 1 enables bits 15:8 and bit 0 enables bits 7:0. Disabled bytes keep their value. The word layout is mode in 4:0, T in 5, F in 6, I in 7, A in 8, GE in 19:16, Q in 27, and V, C, Z, N in 28 to 31.
- R9: A current-status write with mask bit 0 set and an invalid mode code keeps the old mode field. It still updates the other enabled bits, and mode_err_o is 1 for exactly the following cycle.
- R10: With psr_saved_i = 1, a status write updates the saved word of the current mode under the byte mask, with no mode check. spsr_o shows that word. In User and System the write is ignored and spsr_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Write register number |
| wr_data_i | input | 32 | Write data |
| psr_wr_i | input | 1 | Status word write enable |
| psr_saved_i | input | 1 | 0: current word, 1: saved word of current mode |
| psr_mask_i | input | 4 | Byte enable field mask |
| psr_data_i | input | 32 | Status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of current mode, 0 if none |
| privileged_o | output | 1 | Current mode is not User |
| has_saved_o | output | 1 | Current mode owns a saved status word |
| mode_err_o | output | 1 | Invalid mode code was rejected on the previous edge |

## Verification
A mode switch and a general register write can fall in the same cycle. The write must then land in the bank of the old mode. The bench provokes this by driving a status write that moves Supervisor to IRQ, together with a write to r13, in one cycle. It repeats the case for FIQ to User with a write to r9. It then judges the result by reading the affected index in both modes and comparing it with a bench model whose banks are indexed by the old mode. The rejected-mode path is swept over all 32 codes, and the error flag is checked on the cycle after each write and on the cycle after that.

// File: rtl/bkr_pkg.sv
package bkr_pkg;
  localparam int PSR_W     = 32;
  localparam int NUM_BANKS = 6;   // usr/sys, fiq, irq, svc, abt, und
  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  typedef logic [2:0] bank_t;
  localparam bank_t BK_USR = 3'd0;
  localparam bank_t BK_FIQ = 3'd1;
  localparam bank_t BK_IRQ = 3'd2;
  localparam bank_t BK_SVC = 3'd3;
  localparam bank_t BK_ABT = 3'd4;
  localparam bank_t BK_UND = 3'd5;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  function automatic logic mode_ok(input logic [4:0] m);
    case (m)
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bank_t mode_bank(input logic [4:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction
endpackage

// File: rtl/bkr_mode_dec.sv
module bkr_mode_dec
  import bkr_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_t      bank_o,
  output logic       privileged_o,
  output logic       has_saved_o
);
  assign bank_o       = mode_bank(mode_i);
  assign privileged_o = (mode_i != MD_USR);
  assign has_saved_o  = (mode_i != MD_USR) && (mode_i != MD_SYS);
endmodule

// File: rtl/bkr_psr.sv
module bkr_psr
  import bkr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             saved_i,
  input  logic [3:0]       mask_i,
  input  logic [PSR_W-1:0] data_i,
  input  bank_t            bank_i,
  input  logic             has_saved_i,
  output logic [PSR_W-1:0] cpsr_o,
  output logic [PSR_W-1:0] spsr_o,
  output logic             mode_err_o
);
  localparam int NSAVED = NUM_BANKS - 1;

  logic [PSR_W-1:0] cpsr_q, cpsr_d;
  logic [PSR_W-1:0] spsr_q [NSAVED];
  logic [PSR_W-1:0] bmask, cur_merge, sav_merge;
  logic             bad_mode, err_q;
  bank_t            sidx;

  for (genvar b = 0; b < PSR_W/8; b++) begin : g_bmask
    assign bmask[8*b +: 8] = {8{mask_i[b]}};
  end

  assign sidx = bank_t'(bank_i - 3'd1);

  always_comb begin
    bad_mode  = wr_i && !saved_i && mask_i[0] && !mode_ok(data_i[4:0]);
    cur_merge = (cpsr_q & ~bmask) | (data_i & bmask);
    if (bad_mode) cur_merge[4:0] = cpsr_q[4:0];
    cpsr_d    = (wr_i && !saved_i) ? cur_merge : cpsr_q;
    sav_merge = has_saved_i ? ((spsr_q[sidx] & ~bmask) | (data_i & bmask)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= PSR_RESET;
      err_q  <= 1'b0;
      for (int i = 0; i < NSAVED; i++) spsr_q[i] <= '0;
    end else begin
      cpsr_q <= cpsr_d;
      err_q  <= bad_mode;
      if (wr_i && saved_i && has_saved_i) spsr_q[sidx] <= sav_merge;
    end
  end

  assign cpsr_o     = cpsr_q;
  assign spsr_o     = has_saved_i ? spsr_q[sidx] : '0;
  assign mode_err_o = err_q;

  // R9
  bad_mode_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !saved_i && mask_i[0] && !mode_ok(data_i[4:0])
    |=> mode_err_o && (cpsr_o[4:0] == $past(cpsr_o[4:0])));
  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $past(wr_i) && !$past(saved_i));
  // R8
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (mask_i == 4'h0) |=> $stable(cpsr_o) && $stable(spsr_o));
  // R10
  saved_no_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && saved_i |=> $stable(cpsr_o));
endmodule

// File: rtl/bkr_gpr.sv
module bkr_gpr
  import bkr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_OFS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_t             bank_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int NLOW = 8;
  localparam int NHI  = 5;
  localparam logic [DATA_W-1:0] PC_ADD = DATA_W'(PC_OFS);

  logic [DATA_W-1:0] low_q [NLOW];
  logic [DATA_W-1:0] hi_q  [2][NHI];
  logic [DATA_W-1:0] sl_q  [NUM_BANKS][2];
  logic [DATA_W-1:0] pc_q;
  logic              hi_sel;

  assign hi_sel = (bank_i == BK_FIQ);

  function automatic logic [DATA_W-1:0] pick(input logic [3:0] i);
    if (i < 4'd8)        return low_q[i[2:0]];
    else if (i == 4'd15) return pc_q + PC_ADD;
    else if (i >= 4'd13) return sl_q[bank_i][~i[0]];
    else                 return hi_q[hi_sel][3'(i - 4'd8)];
  endfunction

  assign rd_a_data_o = pick(rd_a_idx_i);
  assign rd_b_data_o = pick(rd_b_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      for (int i = 0; i < NLOW; i++) low_q[i] <= '0;
      for (int j = 0; j < 2; j++)
        for (int i = 0; i < NHI; i++) hi_q[j][i] <= '0;
      for (int j = 0; j < NUM_BANKS; j++) begin
        sl_q[j][0] <= '0;
        sl_q[j][1] <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_idx_i < 4'd8)        low_q[wr_idx_i[2:0]] <= wr_data_i;
      else if (wr_idx_i == 4'd15) pc_q <= wr_data_i;
      else if (wr_idx_i >= 4'd13) sl_q[bank_i][~wr_idx_i[0]] <= wr_data_i;
      else                        hi_q[hi_sel][3'(wr_idx_i - 4'd8)] <= wr_data_i;
    end
  end

  // R5
  shared_sp_lr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_idx_i >= 4'd13) && (wr_idx_i != 4'd15) && (bank_i != BK_USR)
    |=> $stable(sl_q[0][0]) && $stable(sl_q[0][1]));
  // R4
  shared_hi_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_idx_i >= 4'd8) && (wr_idx_i <= 4'd12) && (bank_i == BK_FIQ)
    |=> $stable(hi_q[0][0]) && $stable(hi_q[0][4]));
  // R3
  pc_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_idx_i == 4'd15) |=> pc_q == $past(wr_data_i));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bkr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_OFS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              psr_wr_i,
  input  logic              psr_saved_i,
  input  logic [3:0]        psr_mask_i,
  input  logic [PSR_W-1:0]  psr_data_i,
  output logic [PSR_W-1:0]  cpsr_o,
  output logic [PSR_W-1:0]  spsr_o,
  output logic              privileged_o,
  output logic              has_saved_o,
  output logic              mode_err_o
);
  bank_t bank;
  logic  priv, saved;

  bkr_mode_dec u_dec (
    .mode_i       (cpsr_o[4:0]),
    .bank_o       (bank),
    .privileged_o (priv),
    .has_saved_o  (saved)
  );

  bkr_psr u_psr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (psr_wr_i),
    .saved_i     (psr_saved_i),
    .mask_i      (psr_mask_i),
    .data_i      (psr_data_i),
    .bank_i      (bank),
    .has_saved_i (saved),
    .cpsr_o      (cpsr_o),
    .spsr_o      (spsr_o),
    .mode_err_o  (mode_err_o)
  );

  bkr_gpr #(.DATA_W(DATA_W), .PC_OFS(PC_OFS)) u_gpr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bank_i      (bank),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i)
  );

  assign privileged_o = priv;
  assign has_saved_o  = saved;

  // R2
  unpriv_no_saved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !privileged_o |-> !has_saved_o);
  // R9
  mode_always_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ok(cpsr_o[4:0]));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, psr_wr = 1'b0, psr_saved = 1'b0;
  logic [3:0]  psr_mask = '0;
  logic [31:0] psr_data = '0, cpsr, spsr;
  logic        priv, has_sv, merr;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  banked_regfile uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .psr_wr_i(psr_wr), .psr_saved_i(psr_saved), .psr_mask_i(psr_mask),
    .psr_data_i(psr_data), .cpsr_o(cpsr), .spsr_o(spsr),
    .privileged_o(priv), .has_saved_o(has_sv), .mode_err_o(merr)
  );

  logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111};

  // bench model
  logic [31:0] m_low [8];
  logic [31:0] m_hi  [2][5];
  logic [31:0] m_sl  [6][2];
  logic [31:0] m_pc;
  logic [31:0] m_spsr [6];
  logic [31:0] m_cpsr;

  function automatic bit valid_mode(input logic [4:0] m);
    for (int k = 0; k < 7; k++) if (modes[k] == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int sl_of(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] m, input int i);
    if (i < 8)  return m_low[i];
    if (i == 15) return m_pc + 32'd8;
    if (i >= 13) return m_sl[sl_of(m)][i-13];
    return m_hi[(m == 5'b10001) ? 1 : 0][i-8];
  endfunction

  function automatic void model_wr(input logic [4:0] m, input int i, input logic [31:0] d);
    if (i < 8) m_low[i] = d;
    else if (i == 15) m_pc = d;
    else if (i >= 13) m_sl[sl_of(m)][i-13] = d;
    else m_hi[(m == 5'b10001) ? 1 : 0][i-8] = d;
  endfunction

  function automatic logic [31:0] expand(input logic [3:0] mk);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) if (mk[b]) r[8*b +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_psr(input bit sel, input logic [3:0] mk, input logic [31:0] d);
    logic [31:0] bm = expand(mk);
    logic [31:0] nv;
    if (!sel) begin
      nv = (m_cpsr & ~bm) | (d & bm);
      if (mk[0] && !valid_mode(d[4:0])) nv[4:0] = m_cpsr[4:0];
      m_cpsr = nv;
    end else if (sl_of(m_cpsr[4:0]) != 0) begin
      m_spsr[sl_of(m_cpsr[4:0])] = (m_spsr[sl_of(m_cpsr[4:0])] & ~bm) | (d & bm);
    end
  endtask

  task automatic gwr(input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(m_cpsr[4:0], i, d);
  endtask

  task automatic pwr(input bit sel, input logic [3:0] mk, input logic [31:0] d);
    @(negedge clk);
    psr_wr = 1'b1; psr_saved = sel; psr_mask = mk; psr_data = d;
    @(negedge clk);
    psr_wr = 1'b0; psr_saved = 1'b0;
    model_psr(sel, mk, d);
  endtask

  task automatic set_mode(input logic [4:0] m);
    pwr(1'b0, 4'b0001, {24'h0, 3'b110, m});
  endtask

  task automatic both(input logic [4:0] newm, input int i, input logic [31:0] d);
    logic [4:0] oldm = m_cpsr[4:0];
    @(negedge clk);
    psr_wr = 1'b1; psr_saved = 1'b0; psr_mask = 4'b0001; psr_data = {24'h0, 3'b110, newm};
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    psr_wr = 1'b0; wr_en = 1'b0;
    model_wr(oldm, i, d);
    model_psr(1'b0, 4'b0001, {24'h0, 3'b110, newm});
  endtask

  task automatic read_chk(input int i, input string tag);
    rd_a_idx = 4'(i);
    rd_b_idx = 4'(15 - i);
    #1;
    chk(rd_a_data == exp_rd(m_cpsr[4:0], i), tag, rd_a_data, exp_rd(m_cpsr[4:0], i));
    chk(rd_b_data == exp_rd(m_cpsr[4:0], 15 - i), "R7 port b", rd_b_data, exp_rd(m_cpsr[4:0], 15 - i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_low[i] = '0;
    for (int j = 0; j < 2; j++) for (int i = 0; i < 5; i++) m_hi[j][i] = '0;
    for (int j = 0; j < 6; j++) begin m_sl[j][0] = '0; m_sl[j][1] = '0; m_spsr[j] = '0; end
    m_pc = '0;
    m_cpsr = 32'h0000_00D3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cpsr == 32'h0000_00D3, "R1 cpsr reset", cpsr, 32'h0000_00D3);
    chk(spsr == 32'h0, "R1 spsr reset", spsr, 32'h0);
    chk(merr == 1'b0, "R1 err reset", {31'h0, merr}, 32'h0);
    chk(priv && has_sv, "R1 svc flags", {30'h0, priv, has_sv}, 32'h3);
    read_chk(0, "R1 r0 reset");
    read_chk(14, "R1 r14 reset");

    // R2 flags per mode; R3/R4/R5 fill all indices in every mode
    for (int k = 0; k < 7; k++) begin
      set_mode(modes[k]);
      chk(cpsr[4:0] == modes[k], "R2 mode field", {27'h0, cpsr[4:0]}, {27'h0, modes[k]});
      chk(priv == (modes[k] != 5'b10000), "R2 privileged", {31'h0, priv}, {31'h0, modes[k] != 5'b10000});
      chk(has_sv == (modes[k] != 5'b10000 && modes[k] != 5'b11111), "R2 has_saved",
          {31'h0, has_sv}, {31'h0, modes[k] != 5'b10000 && modes[k] != 5'b11111});
      for (int i = 0; i < 16; i++) gwr(i, {8'(k), 8'(i), 16'hC0DE});
    end
    for (int k = 0; k < 7; k++) begin
      set_mode(modes[k]);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (i < 8 || i == 15) read_chk(i, "R3 shared reg");
        else if (i < 13)      read_chk(i, "R4 r8-r12 bank");
        else                  read_chk(i, "R5 r13-r14 bank");
      end
    end

    // R3 pc offset wrap
    gwr(15, 32'hFFFF_FFFC);
    @(negedge clk); rd_a_idx = 4'd15; #1;
    chk(rd_a_data == 32'h0000_0004, "R3 pc wrap", rd_a_data, 32'h4);

    // R7 same-cycle read sees old, next cycle sees new
    @(negedge clk);
    rd_a_idx = 4'd3; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hAAAA_5555; #1;
    chk(rd_a_data == m_low[3], "R7 old before edge", rd_a_data, m_low[3]);
    @(negedge clk); wr_en = 1'b0; m_low[3] = 32'hAAAA_5555;
    chk(rd_a_data == 32'hAAAA_5555, "R7 new after edge", rd_a_data, 32'hAAAA_5555);

    // R8 mask sweep in Supervisor
    set_mode(5'b10011);
    for (int mk = 0; mk < 16; mk++) begin
      logic [31:0] d;
      d = (32'h5A3C_F0C0 ^ (32'(mk) * 32'h1111_1100)) & 32'hFFFF_FFE0 | 32'h13;
      pwr(1'b0, 4'(mk), d);
      chk(cpsr == m_cpsr, "R8 byte mask", cpsr, m_cpsr);
      chk(merr == 1'b0, "R8 no error", {31'h0, merr}, 32'h0);
    end

    // R9 all 32 mode codes
    for (int v = 0; v < 32; v++) begin
      pwr(1'b0, 4'b0001, {24'h0, 3'b101, 5'(v)});
      chk(cpsr == m_cpsr, "R9 mode code", cpsr, m_cpsr);
      chk(merr == !valid_mode(5'(v)), "R9 err pulse", {31'h0, merr}, {31'h0, !valid_mode(5'(v))});
      @(negedge clk);
      chk(merr == 1'b0, "R9 err one cycle", {31'h0, merr}, 32'h0);
    end

    // R10 saved words
    for (int k = 0; k < 7; k++) begin
      set_mode(modes[k]);
      pwr(1'b1, 4'b1111, {8'h9C, 8'(k), 16'h1E00} | 32'h0F);
      chk(spsr == m_spsr[sl_of(modes[k])] && (sl_of(modes[k]) != 0 || spsr == 0),
          "R10 saved write", spsr, (sl_of(modes[k]) != 0) ? m_spsr[sl_of(modes[k])] : 32'h0);
      chk(cpsr == m_cpsr, "R10 cpsr untouched", cpsr, m_cpsr);
    end
    set_mode(5'b10111);
    pwr(1'b1, 4'b0100, 32'h00FF_0000);
    chk(spsr == m_spsr[4], "R10 saved mask", spsr, m_spsr[4]);
    for (int k = 0; k < 7; k++) begin
      set_mode(modes[k]);
      chk(spsr == ((sl_of(modes[k]) != 0) ? m_spsr[sl_of(modes[k])] : 32'h0), "R10 saved kept",
          spsr, (sl_of(modes[k]) != 0) ? m_spsr[sl_of(modes[k])] : 32'h0);
    end

    // R6 mode switch and write in the same cycle
    set_mode(5'b10011);
    both(5'b10010, 13, 32'h1357_2468);
    @(negedge clk); read_chk(13, "R6 new mode bank untouched");
    set_mode(5'b10011);
    @(negedge clk); read_chk(13, "R6 old mode bank written");
    set_mode(5'b10001);
    both(5'b10000, 9, 32'hFEED_0009);
    @(negedge clk); read_chk(9, "R6 user r9 untouched");
    set_mode(5'b10001);
    @(negedge clk); read_chk(9, "R6 fiq r9 written");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule